// File: doc/BRIEF.md
# Logic Analyzer Capture Controller

This block runs a single acquisition of a logic analyzer. When the host sends a start command, the block loads the requested sample count and trigger mode. It then waits for sample strobes. Each strobe is a one-cycle enable taken from whichever sample clock has been selected. On every strobe the block copies the channel inputs into an internal holding register. On the next cycle it writes that word to an external synchronous SRAM, at an address that counts up from zero.

Trigger detection is done elsewhere. This block is only told when the pattern matcher reports a hit, and it records the SRAM address of the sample that matched. In immediate mode, triggering is implied by the start itself and the recorded position is zero. Once the requested number of samples has been written, the block raises a completion flag. The host then reads back the memory and the trigger information.

Top module: `la_capture_ctrl`

## Requirements
- R1: A start pulse received while idle begins a capture: `busy_o` goes high on the next cycle, and the first stored sample is written to address 0.
- R2: Samples are taken only on cycles where `samp_en_i` is high during a capture. Each accepted strobe produces exactly one write. `sram_we_o` is high during the cycle after the strobe, with the channel value from the strobe cycle on `sram_data_o`. Successive writes use consecutive addresses.
- R3: A capture stores exactly the number of samples given on `count_i` at start, then stops, and ignores later strobes. A count of 0 stores nothing.
- R4: `done_o` rises on the cycle after the last write, which is the same cycle `busy_o` falls. It stays high until the next accepted start, which clears it.
- R5: In pattern mode (`mode_i` = 1), the first `trig_hit_i` that coincides with an accepted strobe sets `trig_flag_o` and loads `trig_pos_o` with that sample's address. Later hits in the same capture change nothing.
- R6: In immediate mode (`mode_i` = 0), `trig_flag_o` is set and `trig_pos_o` reads 0 from the cycle after start, and `trig_hit_i` is ignored.
- R7: If no trigger is recorded before the count is reached, `trig_flag_o` stays low and `trig_pos_o` holds all ones.
- R8: A start pulse during a capture is ignored. The count, mode and address sequence of the running capture are unchanged.
- R9: After reset, `busy_o`, `done_o`, `sram_we_o` and `trig_flag_o` are 0, `sram_addr_o` is 0, and `trig_pos_o` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Host start-capture command (one-cycle pulse) |
| count_i | input | AW+1 | Number of samples to store, 0 to 2^AW |
| mode_i | input | 1 | Trigger mode: 0 immediate, 1 pattern |
| samp_en_i | input | 1 | Sample strobe from the selected sample clock |
| chan_i | input | CH | Parallel channel levels |
| trig_hit_i | input | 1 | Hit pulse from the pattern matcher |
| sram_addr_o | output | AW | SRAM write address |
| sram_data_o | output | CH | SRAM write data |
| sram_we_o | output | 1 | SRAM write enable |
| busy_o | output | 1 | Capture in progress |
| done_o | output | 1 | Capture complete |
| trig_flag_o | output | 1 | Trigger recorded |
| trig_pos_o | output | AW | Address of the trigger sample |

## Verification
The bench builds the block with AW = 4 and CH = 8. With these values a full-depth capture of 16 samples is short enough to run. The bench can therefore cover a trigger on the very last address, where the recorded position equals the all-ones "no trigger" value and only the flag tells the two cases apart. The same settings keep captures short enough to also cover a zero count, a start issued during a running capture, and hits that arrive after the count is reached.

// File: rtl/lacap_pkg.sv
// Shared types for the capture controller.
// Assumes: nothing beyond IEEE 1800-2017.
package lacap_pkg;

    // Sequencer state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Trigger mode, encoding visible at the mode_i port
    typedef enum logic {
        TM_IMMEDIATE = 1'b0,
        TM_PATTERN   = 1'b1
    } trig_mode_e;

endpackage

// File: rtl/lacap_seq.sv
// Capture sequencer: accepts a start command from idle, latches the
// sample count, accepts strobes until that many samples are taken,
// then returns to idle with the completion flag raised.
// Assumes: start_i and samp_en_i are single-cycle synchronous pulses.
module lacap_seq #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW:0]   count_i,
    input  logic          samp_en_i,
    output logic          run_o,
    output logic          arm_o,
    output logic          take_o,
    output logic [AW-1:0] idx_o,
    output logic          done_o
);
    import lacap_pkg::*;

    seq_state_e  state_q;
    logic [AW:0] cnt_q;
    logic [AW:0] cfg_q;
    logic        full;

    // Decode: start accepted only from idle, strobe accepted while room remains
    always_comb begin
        full   = (cnt_q == cfg_q);
        arm_o  = (state_q == ST_IDLE) && start_i;
        take_o = (state_q == ST_RUN) && samp_en_i && !full;
        run_o  = (state_q == ST_RUN);
        idx_o  = cnt_q[AW-1:0];
    end

    // State, sample counter, latched count and completion flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            cfg_q   <= '0;
            done_o  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                        cfg_q   <= count_i;
                        done_o  <= 1'b0;
                    end
                end
                default: begin
                    if (full) begin
                        state_q <= ST_IDLE;
                        done_o  <= 1'b1;
                    end else if (take_o) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= cfg_q); // R3

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        run_o |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !run_o); // R4

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && start_i) |=> $stable(cfg_q)); // R8

endmodule

// File: rtl/lacap_wrport.sv
// SRAM write port: the channel word taken on an accepted strobe is held
// in an internal register and presented to the SRAM one cycle later
// together with its address and a one-cycle write enable.
// Assumes: the SRAM captures address, data and enable on the clock edge.
module lacap_wrport #(
    parameter int AW = 10,
    parameter int CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_i,
    input  logic [AW-1:0] idx_i,
    input  logic [CH-1:0] chan_i,
    output logic [AW-1:0] sram_addr_o,
    output logic [CH-1:0] sram_data_o,
    output logic          sram_we_o
);
    // Hold the sample and its address for exactly one write cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sram_addr_o <= '0;
            sram_data_o <= '0;
            sram_we_o   <= 1'b0;
        end else begin
            sram_we_o <= take_i;
            if (take_i) begin
                sram_addr_o <= idx_i;
                sram_data_o <= chan_i;
            end
        end
    end

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(sram_data_o) && $stable(sram_addr_o)); // R2

endmodule

// File: rtl/lacap_trig.sv
// Trigger recorder: on start, latches the mode and presets the flag and
// position (set and zero for immediate, clear and all ones for pattern).
// In pattern mode the first hit on an accepted strobe records that
// sample's address.
// Assumes: trig_hit_i is aligned with the strobe of the matching sample.
module lacap_trig #(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          mode_i,
    input  logic          take_i,
    input  logic [AW-1:0] idx_i,
    input  logic          hit_i,
    output logic          flag_o,
    output logic [AW-1:0] pos_o
);
    import lacap_pkg::*;

    trig_mode_e mode_q;

    // Preset on start, record first qualified hit in pattern mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= TM_IMMEDIATE;
            flag_o <= 1'b0;
            pos_o  <= '1;
        end else if (arm_i) begin
            mode_q <= trig_mode_e'(mode_i);
            if (trig_mode_e'(mode_i) == TM_IMMEDIATE) begin
                flag_o <= 1'b1;
                pos_o  <= '0;
            end else begin
                flag_o <= 1'b0;
                pos_o  <= '1;
            end
        end else if (mode_q == TM_PATTERN && !flag_o && take_i && hit_i) begin
            flag_o <= 1'b1;
            pos_o  <= idx_i;
        end
    end

    AST_IMM_POS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && mode_q == TM_IMMEDIATE) |-> (pos_o == '0)); // R6

    AST_POS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !arm_i) |=> $stable(pos_o) && flag_o); // R5

    AST_NOFLAG_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_o |-> (pos_o == '1)); // R7

endmodule

// File: rtl/la_capture_ctrl.sv
// Logic-analyzer capture controller top: ties the sequencer, SRAM write
// port and trigger recorder together for one acquisition per start.
// Assumes: all inputs are synchronous to clk; count_i <= 2**AW.
module la_capture_ctrl #(
    parameter int AW = 10,
    parameter int CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW:0]   count_i,
    input  logic          mode_i,
    input  logic          samp_en_i,
    input  logic [CH-1:0] chan_i,
    input  logic          trig_hit_i,
    output logic [AW-1:0] sram_addr_o,
    output logic [CH-1:0] sram_data_o,
    output logic          sram_we_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          trig_flag_o,
    output logic [AW-1:0] trig_pos_o
);
    logic          arm;
    logic          take;
    logic [AW-1:0] idx;

    lacap_seq #(.AW(AW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .count_i   (count_i),
        .samp_en_i (samp_en_i),
        .run_o     (busy_o),
        .arm_o     (arm),
        .take_o    (take),
        .idx_o     (idx),
        .done_o    (done_o)
    );

    lacap_wrport #(.AW(AW), .CH(CH)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .take_i      (take),
        .idx_i       (idx),
        .chan_i      (chan_i),
        .sram_addr_o (sram_addr_o),
        .sram_data_o (sram_data_o),
        .sram_we_o   (sram_we_o)
    );

    lacap_trig #(.AW(AW)) u_trig (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (arm),
        .mode_i (mode_i),
        .take_i (take),
        .idx_i  (idx),
        .hit_i  (trig_hit_i),
        .flag_o (trig_flag_o),
        .pos_o  (trig_pos_o)
    );

    AST_WE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we_o |-> $past(busy_o)); // R2

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && !done_o)); // R1

endmodule

// File: tb/la_capture_ctrl_bench.sv
// Bench: table-driven captures followed by directed corner cases.
module la_capture_ctrl_bench;
    localparam int AW = 4;
    localparam int CH = 8;
    localparam int ONES = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW:0]   count_i = '0;
    logic          mode_i = 1'b0;
    logic          samp_en_i = 1'b0;
    logic [CH-1:0] chan_i = '0;
    logic          trig_hit_i = 1'b0;
    logic [AW-1:0] sram_addr_o;
    logic [CH-1:0] sram_data_o;
    logic          sram_we_o;
    logic          busy_o, done_o, trig_flag_o;
    logic [AW-1:0] trig_pos_o;

    la_capture_ctrl #(.AW(AW), .CH(CH)) u_la_capture_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
        .mode_i(mode_i), .samp_en_i(samp_en_i), .chan_i(chan_i),
        .trig_hit_i(trig_hit_i), .sram_addr_o(sram_addr_o),
        .sram_data_o(sram_data_o), .sram_we_o(sram_we_o), .busy_o(busy_o),
        .done_o(done_o), .trig_flag_o(trig_flag_o), .trig_pos_o(trig_pos_o)
    );

    always #5 clk = ~clk;

    int nchk = 0;
    int nerr = 0;
    int wcount = 0;
    int addr_err = 0;
    logic [CH-1:0] wmem [32];
    bit finished = 0;

    // Vector table: mode, count, idle gap between strobes, hit index (-1 none)
    localparam int NV = 6;
    localparam int V_MODE [NV] = '{1, 1, 0, 1, 1, 1};
    localparam int V_CNT  [NV] = '{5, 8, 4, 16, 3, 6};
    localparam int V_GAP  [NV] = '{0, 2, 1, 0, 3, 0};
    localparam int V_HIT  [NV] = '{2, -1, 1, 15, 0, 7};

    // Record every SRAM write away from the active edge
    always @(negedge clk) begin
        if (sram_we_o) begin
            if (int'(sram_addr_o) != wcount) addr_err++;
            wmem[wcount % 32] = sram_data_o;
            wcount++;
        end
    end

    function automatic logic [CH-1:0] pat(input int v, input int i);
        return CH'((i * 37 + v * 11 + 5) & 255);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(input int mode, input int cnt);
        @(negedge clk);
        start_i = 1'b1; mode_i = mode[0]; count_i = (AW+1)'(cnt);
        wcount = 0; addr_err = 0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic strobe(input int v, input int i, input bit hit);
        samp_en_i = 1'b1; chan_i = pat(v, i); trig_hit_i = hit;
        @(negedge clk);
        samp_en_i = 1'b0; trig_hit_i = 1'b0;
    endtask

    task automatic run_vec(input int v);
        int mode = V_MODE[v];
        int cnt = V_CNT[v];
        int hit = V_HIT[v];
        int exp_flag, exp_pos;
        do_start(mode, cnt);
        chk("R1 busy after start", int'(busy_o), 1);
        chk("R4 done cleared by start", int'(done_o), 0);
        for (int i = 0; i < cnt + 2; i++) begin
            strobe(v, i, (i == hit) || (hit >= 0 && i == hit + 2));
            repeat (V_GAP[v]) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk("R3 write count", wcount, cnt);
        chk("R1 R2 address sequence", addr_err, 0);
        for (int j = 0; j < cnt; j++) chk("R2 data", int'(wmem[j]), int'(pat(v, j)));
        chk("R4 done held", int'(done_o), 1);
        chk("R3 stopped", int'(busy_o), 0);
        if (mode == 0) begin
            exp_flag = 1; exp_pos = 0;
            chk("R6 flag", int'(trig_flag_o), exp_flag);
            chk("R6 pos", int'(trig_pos_o), exp_pos);
        end else if (hit >= 0 && hit < cnt) begin
            exp_flag = 1; exp_pos = hit;
            chk("R5 flag", int'(trig_flag_o), exp_flag);
            chk("R5 pos", int'(trig_pos_o), exp_pos);
        end else begin
            exp_flag = 0; exp_pos = ONES;
            chk("R7 flag", int'(trig_flag_o), exp_flag);
            chk("R7 pos", int'(trig_pos_o), exp_pos);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 busy", int'(busy_o), 0);
        chk("R9 done", int'(done_o), 0);
        chk("R9 we", int'(sram_we_o), 0);
        chk("R9 flag", int'(trig_flag_o), 0);
        chk("R9 pos", int'(trig_pos_o), ONES);
        chk("R9 addr", int'(sram_addr_o), 0);
        rst_n = 1'b1;
        // R2: strobes while idle write nothing
        strobe(9, 0, 1'b1);
        @(negedge clk);
        chk("R2 idle strobe", wcount, 0);

        for (int v = 0; v < NV; v++) run_vec(v);

        // R6: immediate trigger visible right after start, before any sample
        do_start(0, 2);
        chk("R6 flag at start", int'(trig_flag_o), 1);
        chk("R6 pos at start", int'(trig_pos_o), 0);
        // R4: done timing against the last write
        strobe(7, 0, 1'b0);
        @(negedge clk);
        samp_en_i = 1'b1; chan_i = pat(7, 1);
        @(negedge clk);
        samp_en_i = 1'b0;
        chk("R4 last write", int'(sram_we_o), 1);
        chk("R4 done not yet", int'(done_o), 0);
        @(negedge clk);
        chk("R4 done rises", int'(done_o), 1);
        chk("R4 busy falls", int'(busy_o), 0);
        chk("R4 we drops", int'(sram_we_o), 0);

        // R3: zero count stores nothing
        do_start(1, 0);
        strobe(8, 0, 1'b1);
        strobe(8, 1, 1'b0);
        @(negedge clk);
        chk("R3 zero count writes", wcount, 0);
        chk("R3 zero count done", int'(done_o), 1);
        chk("R7 zero count flag", int'(trig_flag_o), 0);

        // R8: start during capture ignored
        do_start(1, 4);
        strobe(5, 0, 1'b0);
        strobe(5, 1, 1'b0);
        start_i = 1'b1; mode_i = 1'b0; count_i = 2;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 flag unchanged", int'(trig_flag_o), 0);
        strobe(5, 2, 1'b1);
        strobe(5, 3, 1'b0);
        strobe(5, 4, 1'b0);
        repeat (2) @(negedge clk);
        chk("R8 writes", wcount, 4);
        chk("R8 addresses", addr_err, 0);
        chk("R8 trigger pos", int'(trig_pos_o), 2);
        chk("R8 done", int'(done_o), 1);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nerr++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule